// File: doc/BRIEF.md
# Two-Level Virtual Address Translation Walker

This block turns a 32-bit virtual address into a 32-bit physical address by walking a two-level page table that lives in ordinary memory. A requester offers a virtual address, an access kind (read, write or execute) and a user-mode flag. The block then fetches one directory word and one leaf word through a single-outstanding memory port. It checks presence and permissions, and it returns either the translated address or a fault code in a one-cycle response pulse.

Each table word carries its flags in the top bits and a 20-bit frame number in the low bits. On a successful translation the block marks the leaf as used, and also as modified for a write. It stores the leaf word back only when marking it changes the word. Software handles the faults, allocates the frames and does any caching. The base of the directory comes from a root input, which the block samples when it accepts a request.

Top module: `pt_walker`

## Requirements
- R1: The first memory access of a walk is a read at `root_base + vaddr[31:22]*4`.
- R2: After a present directory word, the second access is a read at `dir_word[19:0]*4096 + vaddr[21:12]*4`. The directory word's bits 29..25 (read/write/execute/dirty/accessed) have no effect.
- R3: A successful walk responds with code 0 and `rsp_addr = {leaf[19:0], vaddr[11:0]}`.
- R4: A directory word with bit 31 (present) = 0 ends the walk with code 1 and `rsp_addr = 0`. No leaf read and no write take place.
- R5: A leaf word with bit 31 = 0 ends the walk with code 2 and `rsp_addr = 0`. No write takes place.
- R6: A user access (`req_user` = 1) faults with code 3 when bit 30 (supervisor) is set in the directory word or in the leaf word. A supervisor access to the same page succeeds.
- R7: Access kind encodes as 0 read, 1 write, 2 execute and 3 reserved. The kind is checked against leaf bit 29, 28 or 27 respectively, and a clear bit gives code 3. Kind 3 always gives code 3.
- R8: On success the leaf word is written back to the same address with bit 25 (accessed) set. For a write access bit 26 (dirty) is also set. The response follows the write's acknowledge.
- R9: When the updated leaf word equals the word that was read, no write takes place.
- R10: `req_ready` is low from the cycle after acceptance until the response. `rsp_valid` is high for exactly one cycle per request.
- R11: After reset `req_ready` = 1, `rsp_valid` = 0 and `mem_req` = 0.
- R12: While `mem_req` is high and not acknowledged, `mem_addr`, `mem_we` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 32 | Physical byte address of the directory page |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_user | input | 1 | 1 = user-mode access |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion of the pending access |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_code | output | 2 | 0 ok, 1 directory absent, 2 leaf absent, 3 protection |
| rsp_addr | output | 32 | Physical address on success, zero on fault |

## Verification
The bench covers the leaf words whose flags are already set. A walker that always writes would issue a spurious store there, and the memory model rejects any store it does not expect. Faults at each level are checked for their code and for the absence of any further access: a walker that ignores presence would go on to read from frame zero or write a word back. The bench also covers supervisor bits placed only in the directory word or only in the leaf word, the reserved access kind, and noise in a directory word's permission bits. A walker that checks the wrong level, or decodes the permission field off by one, returns the wrong code or the wrong table address. Memory latency is varied so that a walker that changes its request before the acknowledge shows a mismatched address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  typedef enum logic [1:0] {
    FLT_NONE        = 2'd0,
    FLT_DIR_ABSENT  = 2'd1,
    FLT_LEAF_ABSENT = 2'd2,
    FLT_PROT        = 2'd3
  } fault_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_LEAF,
    ST_WB
  } walk_st_t;

  // Flag positions counted down from the most significant entry bit.
  localparam int FL_PRESENT = 0;
  localparam int FL_SUPER   = 1;
  localparam int FL_RD      = 2;
  localparam int FL_WR      = 3;
  localparam int FL_EX      = 4;
  localparam int FL_DIRTY   = 5;
  localparam int FL_USED    = 6;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0]        root,
  input  logic [ADDR_W-1:0]        vaddr,
  input  logic [ADDR_W-PAGE_W-1:0] dir_pfn,
  output logic [ADDR_W-1:0]        dir_addr,
  output logic [ADDR_W-1:0]        leaf_addr
);
  localparam int PFN_W  = ADDR_W - PAGE_W;
  localparam int HI_LSB = PAGE_W + IDX_W;
  localparam int PAD_W  = ADDR_W - IDX_W - 2;

  logic [IDX_W-1:0] hi_idx;
  logic [IDX_W-1:0] lo_idx;

  assign hi_idx    = vaddr[HI_LSB +: IDX_W];
  assign lo_idx    = vaddr[PAGE_W +: IDX_W];
  assign dir_addr  = root + {{PAD_W{1'b0}}, hi_idx, 2'b00};
  assign leaf_addr = {dir_pfn[PFN_W-1:0], {PAGE_W{1'b0}}}
                   + {{PAD_W{1'b0}}, lo_idx, 2'b00};
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
#(
  parameter int  ENT_W = 32,
  parameter bit  LEAF  = 1'b1
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [1:0]       acc,
  input  logic             user,
  output fault_t           code
);
  localparam int B_P = ENT_W - 1 - FL_PRESENT;
  localparam int B_S = ENT_W - 1 - FL_SUPER;
  localparam int B_R = ENT_W - 1 - FL_RD;
  localparam int B_W = ENT_W - 1 - FL_WR;
  localparam int B_X = ENT_W - 1 - FL_EX;

  generate
    if (LEAF) begin : g_leaf
      logic allow;
      always_comb begin
        case (acc)
          ACC_READ:  allow = entry[B_R];
          ACC_WRITE: allow = entry[B_W];
          ACC_EXEC:  allow = entry[B_X];
          default:   allow = 1'b0;
        endcase
        if (!entry[B_P])             code = FLT_LEAF_ABSENT;
        else if (user && entry[B_S]) code = FLT_PROT;
        else if (!allow)             code = FLT_PROT;
        else                         code = FLT_NONE;
      end
    end else begin : g_dir
      // Directory level: only presence and the privilege bit count.
      always_comb begin
        if (!entry[B_P])             code = FLT_DIR_ABSENT;
        else if (user && entry[B_S]) code = FLT_PROT;
        else                         code = FLT_NONE;
      end
    end
  endgenerate
endmodule

// File: rtl/ptw_flag_update.sv
module ptw_flag_update
  import ptw_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             is_write,
  output logic [ENT_W-1:0] new_entry,
  output logic             changed
);
  localparam int B_D = ENT_W - 1 - FL_DIRTY;
  localparam int B_A = ENT_W - 1 - FL_USED;

  always_comb begin
    new_entry      = entry;
    new_entry[B_A] = 1'b1;
    if (is_write) new_entry[B_D] = 1'b1;
  end

  assign changed = (new_entry != entry);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int PFN_W = ADDR_W - PAGE_W;
  localparam int ENT_W = ADDR_W;
  localparam int B_A   = ENT_W - 1 - FL_USED;

  walk_st_t          state_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic [1:0]        acc_q;
  logic              user_q;
  logic [ADDR_W-1:0] paddr_q;

  logic              mem_req_q, mem_we_q, rsp_valid_q;
  logic [ADDR_W-1:0] mem_addr_q, mem_wdata_q, rsp_addr_q;
  fault_t            rsp_code_q;

  logic [ADDR_W-1:0] va_sel, dir_addr, leaf_addr, upd_word;
  fault_t            dir_code, leaf_code;
  logic              upd_changed;
  logic [1:0]        acc_sel;
  logic              user_sel;

  assign va_sel   = (state_q == ST_IDLE) ? req_vaddr : vaddr_q;
  assign acc_sel  = acc_q;
  assign user_sel = user_q;

  ptw_addr_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_addr (
    .root     (root_base),
    .vaddr    (va_sel),
    .dir_pfn  (mem_rdata[PFN_W-1:0]),
    .dir_addr (dir_addr),
    .leaf_addr(leaf_addr)
  );

  ptw_perm_check #(.ENT_W(ENT_W), .LEAF(1'b0)) u_dir_chk (
    .entry(mem_rdata), .acc(acc_sel), .user(user_sel), .code(dir_code)
  );

  ptw_perm_check #(.ENT_W(ENT_W), .LEAF(1'b1)) u_leaf_chk (
    .entry(mem_rdata), .acc(acc_sel), .user(user_sel), .code(leaf_code)
  );

  ptw_flag_update #(.ENT_W(ENT_W)) u_flags (
    .entry    (mem_rdata),
    .is_write (acc_q == ACC_WRITE),
    .new_entry(upd_word),
    .changed  (upd_changed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      vaddr_q     <= '0;
      acc_q       <= '0;
      user_q      <= 1'b0;
      paddr_q     <= '0;
      mem_req_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= FLT_NONE;
      rsp_addr_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q    <= req_vaddr;
            acc_q      <= req_acc;
            user_q     <= req_user;
            mem_req_q  <= 1'b1;
            mem_we_q   <= 1'b0;
            mem_addr_q <= dir_addr;
            state_q    <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (mem_ack) begin
            if (dir_code != FLT_NONE) begin
              mem_req_q   <= 1'b0;
              rsp_valid_q <= 1'b1;
              rsp_code_q  <= dir_code;
              rsp_addr_q  <= '0;
              state_q     <= ST_IDLE;
            end else begin
              mem_addr_q <= leaf_addr;
              state_q    <= ST_LEAF;
            end
          end
        end
        ST_LEAF: begin
          if (mem_ack) begin
            if (leaf_code != FLT_NONE) begin
              mem_req_q   <= 1'b0;
              rsp_valid_q <= 1'b1;
              rsp_code_q  <= leaf_code;
              rsp_addr_q  <= '0;
              state_q     <= ST_IDLE;
            end else if (upd_changed) begin
              paddr_q     <= {mem_rdata[PFN_W-1:0], vaddr_q[PAGE_W-1:0]};
              mem_we_q    <= 1'b1;
              mem_wdata_q <= upd_word;
              state_q     <= ST_WB;
            end else begin
              mem_req_q   <= 1'b0;
              rsp_valid_q <= 1'b1;
              rsp_code_q  <= FLT_NONE;
              rsp_addr_q  <= {mem_rdata[PFN_W-1:0], vaddr_q[PAGE_W-1:0]};
              state_q     <= ST_IDLE;
            end
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            mem_req_q   <= 1'b0;
            mem_we_q    <= 1'b0;
            rsp_valid_q <= 1'b1;
            rsp_code_q  <= FLT_NONE;
            rsp_addr_q  <= paddr_q;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = mem_req_q;
  assign mem_we    = mem_we_q;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = rsp_code_q;
  assign rsp_addr  = rsp_addr_q;

  // R12: a pending access holds its address, direction and data until acknowledged.
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10: the response pulse lasts one cycle.
  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R10: acceptance makes the walker busy.
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R11: an idle walker has no memory access pending.
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req);

  // R8: every store of a leaf word carries the accessed flag.
  a_r8_wb_marks_used: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[B_A]);

  // R4/R5: a fault response is never produced while a store is pending.
  a_r5_no_store_on_fault: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != 2'd0) |-> !mem_we);

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] root_base = 32'h0010_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_addr;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_user(req_user),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_addr(rsp_addr)
  );

  typedef struct packed { logic we; logic [31:0] addr; logic [31:0] data; } op_t;
  typedef struct packed { logic [1:0] code; logic [31:0] addr; } rsp_t;

  logic [31:0] mem [int unsigned];
  op_t   op_q[$];
  rsp_t  rsp_q[$];
  string tag = "R11";
  int    n_tests = 0;
  int    n_fail  = 0;
  int    lat     = 0;
  int    wait_cnt = 0;
  int    cycles  = 0;
  bit    done    = 1'b0;
  bit    prev_rsp = 1'b0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // Memory model: serves one access at a time and checks it against the expected list.
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      wait_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt < lat) wait_cnt++;
      else begin
        wait_cnt = 0;
        if (op_q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL %s actual=unexpected access we=%0b addr=%h expected=none", tag, mem_we, mem_addr);
        end else begin
          op_t e;
          e = op_q.pop_front();
          chk(tag, {31'b0, mem_we}, {31'b0, e.we});
          chk(tag, mem_addr, e.addr);
          if (e.we) chk(tag, mem_wdata, e.data);
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
        else        mem_rdata = rd(mem_addr);
        mem_ack = 1'b1;
      end
    end
  end

  // Monitor: compares each response pulse against the scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_rsp) chk("R10 pulse", {31'b0, rsp_valid}, 32'd0);
      if (rsp_valid) begin
        if (rsp_q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL %s actual=unexpected response expected=none", tag);
        end else begin
          rsp_t e;
          e = rsp_q.pop_front();
          chk(tag, {30'b0, rsp_code}, {30'b0, e.code});
          chk(tag, rsp_addr, e.addr);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Driver: computes expected accesses and result from the requirements, then issues the request.
  task automatic walk(string r, logic [31:0] va, logic [1:0] acc, logic user);
    logic [31:0] da, de, la, le, nv;
    logic allow;
    rsp_t res;
    tag = r;
    da = root_base + {20'b0, va[31:22], 2'b00};                 // R1
    op_q.push_back('{we: 1'b0, addr: da, data: 32'h0});
    de = rd(da);
    if (!de[31]) res = '{code: 2'd1, addr: 32'h0};             // R4
    else if (user && de[30]) res = '{code: 2'd3, addr: 32'h0}; // R6
    else begin
      la = {de[19:0], 12'h000} + {20'b0, va[21:12], 2'b00};     // R2
      op_q.push_back('{we: 1'b0, addr: la, data: 32'h0});
      le = rd(la);
      case (acc)
        2'd0: allow = le[29];
        2'd1: allow = le[28];
        2'd2: allow = le[27];
        default: allow = 1'b0;                                  // R7
      endcase
      if (!le[31]) res = '{code: 2'd2, addr: 32'h0};           // R5
      else if ((user && le[30]) || !allow) res = '{code: 2'd3, addr: 32'h0};
      else begin
        nv = le | 32'h0200_0000 | ((acc == 2'd1) ? 32'h0400_0000 : 32'h0); // R8
        if (nv != le) op_q.push_back('{we: 1'b1, addr: la, data: nv});     // R9
        res = '{code: 2'd0, addr: {le[19:0], va[11:0]}};        // R3
      end
    end
    rsp_q.push_back(res);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy", {31'b0, req_ready}, 32'd0);
    while (rsp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk({r, " leftover accesses"}, op_q.size(), 32'd0);
    op_q.delete();
  endtask

  initial begin
    // Directory page at 0x00100000; entries: present=31 super=30 R=29 W=28 X=27 D=26 A=25.
    mem[32'h0010_0080] = 32'h8000_0101;
    mem[32'h0010_0BFC] = 32'hBE00_0104;  // R2: stray R/W/X/D/A bits in a directory word
    mem[32'h0010_0C00] = 32'hC000_0106;  // supervisor-only directory word
    mem[32'h0010_1100] = 32'hA800_0102;  // R+X
    mem[32'h0010_1104] = 32'hB000_0103;  // R+W
    mem[32'h0010_110C] = 32'hE800_0108;  // supervisor R+X
    mem[32'h0010_4FFC] = 32'hB000_0105;  // R+W
    mem[32'h0010_6000] = 32'hF000_0107;  // supervisor R+W

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 ready", {31'b0, req_ready}, 32'd1);
    chk("R11 rsp", {31'b0, rsp_valid}, 32'd0);
    chk("R11 mem", {31'b0, mem_req}, 32'd0);

    walk("R1 R3 R8 first read",      32'h0804_0123, 2'd0, 1'b1);
    walk("R9 repeat read",           32'h0804_0FFF, 2'd0, 1'b1);
    walk("R7 write to read-only",    32'h0804_0010, 2'd1, 1'b1);
    walk("R9 exec flags set",        32'h0804_0004, 2'd2, 1'b1);
    walk("R8 write sets dirty",      32'h0804_1008, 2'd1, 1'b1);
    walk("R9 read after write",      32'h0804_1000, 2'd0, 1'b1);
    lat = 3;
    walk("R2 R12 stack slow memory", 32'hBFFF_FFFC, 2'd0, 1'b1);
    lat = 0;
    walk("R4 directory absent",      32'h4000_0000, 2'd0, 1'b1);
    walk("R5 leaf absent",           32'h0804_2000, 2'd0, 1'b0);
    walk("R6 user on super dir",     32'hC000_0010, 2'd0, 1'b1);
    walk("R6 super on super dir",    32'hC000_0010, 2'd0, 1'b0);
    walk("R6 user on super leaf",    32'h0804_3000, 2'd2, 1'b1);
    walk("R6 super on super leaf",   32'h0804_3ABC, 2'd2, 1'b0);
    walk("R7 reserved kind",         32'h0804_1000, 2'd3, 1'b0);
    walk("R7 exec without X",        32'h0804_1000, 2'd2, 1'b1);
    lat = 2;
    walk("R8 R12 stack write",       32'hBFFF_F800, 2'd1, 1'b1);
    lat = 1;
    walk("R9 stack write again",     32'hBFFF_F804, 2'd1, 1'b1);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule